// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the flow-control core of a four-wide register rename stage. In every cycle it decides which slots of an instruction group go downstream. It takes the group either from the decode side or from its own skid buffer. The decision is based on the space that the reorder buffer and the issue queue report. Those reports are stale by the feedback delay, so each one is debited by the rename width times that delay before use.

When the stage cannot accept a whole group, it forwards the slots it can. It parks the group in a skid buffer that holds whole groups, and it records how far into the parked group it got. It then raises the upstream stall. Once downstream space and free physical registers return, it drains the skid buffer in arrival order, resuming at the recorded slot. A squash, or a reorder buffer that is still squashing, discards everything parked and holds the stage quiet until both indications drop.

The actual register mapping is done elsewhere. This block only produces the per-slot forward mask, a flag that says whether the mask refers to the skid head, the upstream stall and the control state.

Top module: `rename_stall_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it with no input, `state` is 0 (idle), `stall_up` is 0 and `out_mask` is 0.
- R2: The usable credit of each queue is its reported free count minus WIDTH*FB_DELAY (4 by default), evaluated as a signed value. The slot limit is the smaller of the two credits. The number of slots consumed in a cycle never exceeds a positive limit.
- R3: In idle, running or unblocking with a limit of zero or less, no slot is forwarded. The current group is parked, the state becomes blocked (code 2) and `stall_up` is 1.
- R4: If the limit is positive but smaller than the number of slots left in the source group, exactly the first `limit` remaining slots are consumed. The group is parked, the state becomes blocked, and the rest of the group later resumes at the first unconsumed slot.
- R5: A downstream stall (`exec_stall` or `commit_stall`) in idle or running forwards nothing, parks a nonempty incoming group and enters blocked with `stall_up` at 1.
- R6: In blocked, nothing is forwarded and incoming groups are appended to the skid buffer. The state moves on only when neither stall is high, both credits are positive and `free_regs` is nonzero. It then goes to unblocking (code 3), or to running (code 1) if nothing is parked.
- R7: In unblocking, slots come from the oldest parked group starting at the saved slot, and `out_from_skid` is 1. A fully consumed head is removed and any incoming group is appended. The state returns to running once the buffer is empty.
- R8: A slot whose `in_squashed` (or parked squashed) bit is set is never forwarded, but it still counts as one consumed slot against the limit.
- R9: When `squash` or `rob_squashing` is high in any state except squashing, the parked groups and the slot position are discarded, nothing is forwarded and the state becomes squashing (code 4). Squashing leaves to running in the first cycle in which both are low.
- R10: A group that is completely consumed without blocking resets the slot position, so the next group starts at slot 0.
- R11: `stall_up` is 1 exactly when the state entered at the next clock edge is blocked or unblocking.
- R12: In idle or running, a cycle with `in_count` of 0 and no stall or squash forwards nothing and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_count | input | 3 | Number of valid slots in the incoming group (0 to 4) |
| in_squashed | input | 4 | Per-slot squashed flags of the incoming group |
| rob_free | input | 8 | Free reorder buffer entries as last reported |
| iq_free | input | 8 | Free issue queue entries as last reported |
| exec_stall | input | 1 | Stall request from the execute side |
| commit_stall | input | 1 | Stall request from the commit side |
| squash | input | 1 | Squash request |
| rob_squashing | input | 1 | Reorder buffer still walking a squash |
| free_regs | input | 8 | Free physical register count |
| out_mask | output | 4 | Slot positions forwarded downstream this cycle |
| out_from_skid | output | 1 | Forwarded slots belong to the skid buffer head |
| stall_up | output | 1 | Stall request to the decode side |
| state | output | 3 | Control state: 0 idle, 1 running, 2 blocked, 3 unblocking, 4 squashing |

## Verification
The bench pushes the credit debit to both edges. A limit of exactly the remaining slot count must forward the whole group and stay running; a design off by one here would block needlessly or run past the credit. A credit that drops to zero or below must block with nothing sent; a design comparing unsigned would see a huge credit instead. Partial groups are resumed from the skid buffer while new groups keep arriving behind them. A design that loses the slot position would resend slots or skip them, and one that pops the head early would drop the tail. Squashes arrive during blocked and unblocking states with groups parked, so stale parked slots appearing after recovery would be caught, and squashed slots are mixed in so that a design counting only forwarded slots against the limit would overrun it.

// File: rtl/rename_stall_ctl.sv
module rename_stall_ctl #(
  parameter int WIDTH      = 4,
  parameter int SKID_DEPTH = 4,
  parameter int FB_DELAY   = 1,
  parameter int CNT_W      = 8,
  parameter int REG_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(WIDTH+1)-1:0] in_count,
  input  logic [WIDTH-1:0]           in_squashed,
  input  logic [CNT_W-1:0]           rob_free,
  input  logic [CNT_W-1:0]           iq_free,
  input  logic                       exec_stall,
  input  logic                       commit_stall,
  input  logic                       squash,
  input  logic                       rob_squashing,
  input  logic [REG_W-1:0]           free_regs,
  output logic [WIDTH-1:0]           out_mask,
  output logic                       out_from_skid,
  output logic                       stall_up,
  output logic [2:0]                 state
);
  localparam int NW  = $clog2(WIDTH + 1);
  localparam int PW  = (SKID_DEPTH > 1) ? $clog2(SKID_DEPTH) : 1;
  localparam int OW  = $clog2(SKID_DEPTH + 1);
  localparam int CW  = CNT_W + 2;
  localparam int SUB = WIDTH * FB_DELAY;

  typedef enum logic [2:0] {S_IDLE = 3'd0, S_RUN = 3'd1, S_BLK = 3'd2, S_UNBLK = 3'd3, S_SQ = 3'd4} st_t;

  st_t st, st_n;
  logic [NW-1:0]    sk_cnt [SKID_DEPTH];
  logic [WIDTH-1:0] sk_sq  [SKID_DEPTH];
  logic [PW-1:0]    rd, wr;
  logic [OW-1:0]    occ;
  logic [NW-1:0]    off, off_n, base, src_cnt;
  logic [WIDTH-1:0] src_sq;
  logic [NW:0]      avail, n;
  logic             push, pop, flush, go, push_ok, sq_any, ds_stall, src_skid;
  logic signed [CW-1:0] rob_c, iq_c, lim_s, avail_s;

  assign sq_any   = squash | rob_squashing;
  assign ds_stall = exec_stall | commit_stall;
  assign rob_c    = $signed({2'b00, rob_free}) - $signed(CW'(SUB));
  assign iq_c     = $signed({2'b00, iq_free}) - $signed(CW'(SUB));
  assign lim_s    = (rob_c < iq_c) ? rob_c : iq_c;

  assign src_skid = (st == S_UNBLK);
  assign src_cnt  = src_skid ? sk_cnt[rd] : in_count;
  assign src_sq   = src_skid ? sk_sq[rd] : in_squashed;
  assign base     = src_skid ? off : '0;
  assign avail    = {1'b0, src_cnt} - {1'b0, base};
  assign avail_s  = CW'(avail);

  always_comb begin
    st_n  = st;
    push  = 1'b0;
    pop   = 1'b0;
    flush = 1'b0;
    go    = 1'b0;
    n     = '0;
    off_n = off;
    case (st)
      S_IDLE, S_RUN, S_UNBLK: begin
        if (sq_any) begin
          flush = 1'b1;
          off_n = '0;
          st_n  = S_SQ;
        end else if (ds_stall) begin
          push = 1'b1;
          st_n = S_BLK;
        end else if (st != S_UNBLK && in_count == '0) begin
          st_n = st;
        end else if (lim_s <= 0) begin
          push = 1'b1;
          st_n = S_BLK;
        end else if (lim_s < avail_s) begin
          go    = 1'b1;
          n     = lim_s[NW:0];
          off_n = base + NW'(n);
          push  = 1'b1;
          st_n  = S_BLK;
        end else begin
          go    = 1'b1;
          n     = avail;
          off_n = '0;
          if (st == S_UNBLK) begin
            pop  = 1'b1;
            push = 1'b1;
            st_n = (occ == OW'(1) && in_count == '0) ? S_RUN : S_UNBLK;
          end else begin
            st_n = S_RUN;
          end
        end
      end
      S_BLK: begin
        push = 1'b1;
        if (sq_any) begin
          flush = 1'b1;
          off_n = '0;
          st_n  = S_SQ;
        end else if (!ds_stall && rob_c > 0 && iq_c > 0 && free_regs != '0) begin
          st_n = (occ == '0 && in_count == '0) ? S_RUN : S_UNBLK;
        end
      end
      S_SQ: begin
        flush = 1'b1;
        if (!sq_any) st_n = S_RUN;
      end
      default: st_n = S_IDLE;
    endcase
  end

  assign push_ok = push && !flush && in_count != '0 && (occ != OW'(SKID_DEPTH) || pop);

  for (genvar i = 0; i < WIDTH; i++) begin : g_slot
    assign out_mask[i] = go && ((NW+1)'(i) >= {1'b0, base}) &&
                         ((NW+1)'(i) < ({1'b0, base} + n)) && !src_sq[i];
  end

  assign out_from_skid = go && src_skid;
  assign stall_up      = (st_n == S_BLK) || (st_n == S_UNBLK);
  assign state         = st;

  always_ff @(posedge clk) begin
    if (push_ok) begin
      sk_cnt[wr] <= in_count;
      sk_sq[wr]  <= in_squashed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      off <= '0;
      rd  <= '0;
      wr  <= '0;
      occ <= '0;
    end else begin
      st  <= st_n;
      off <= off_n;
      if (flush) begin
        rd  <= '0;
        wr  <= '0;
        occ <= '0;
      end else begin
        if (push_ok) wr <= (wr == PW'(SKID_DEPTH - 1)) ? '0 : wr + 1'b1;
        if (pop)     rd <= (rd == PW'(SKID_DEPTH - 1)) ? '0 : rd + 1'b1;
        occ <= occ + OW'(push_ok) - OW'(pop);
      end
    end
  end

  AST_LIMIT_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_s <= 0) |-> (out_mask == '0)) else $error("limit"); // R2
  AST_PARTIAL_MEANS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (go && lim_s < avail_s) |=> (state == S_BLK)) else $error("partial"); // R4
  AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLK) |-> (out_mask == '0 && !out_from_skid)) else $error("blocked"); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLK && occ == OW'(SKID_DEPTH)) |-> (in_count == '0)) else $error("overflow"); // R6
  AST_UNBLOCK_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_UNBLK) |-> (occ != '0)) else $error("unblock empty"); // R7
  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SQ) |-> (out_mask == '0 && !stall_up)) else $error("squash out"); // R9
  AST_SQUASH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SQ && !sq_any) |=> (state == S_RUN)) else $error("squash exit"); // R9
  AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_any && state != S_SQ) |=> (occ == '0 && state == S_SQ)) else $error("squash flush"); // R9
endmodule

// File: tb/rename_stall_ctl_bench.sv
module rename_stall_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] in_count;
  logic [3:0] in_squashed;
  logic [7:0] rob_free, iq_free, free_regs;
  logic       exec_stall, commit_stall, squash, rob_squashing;
  logic [3:0] out_mask;
  logic       out_from_skid, stall_up;
  logic [2:0] state;

  int total = 0;
  int bad   = 0;

  int       m_st;
  int       m_off;
  int       m_occ;
  int       q_cnt [D];
  bit [3:0] q_sq  [D];

  rename_stall_ctl u_rename_stall_ctl (
    .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_squashed(in_squashed),
    .rob_free(rob_free), .iq_free(iq_free), .exec_stall(exec_stall),
    .commit_stall(commit_stall), .squash(squash), .rob_squashing(rob_squashing),
    .free_regs(free_regs), .out_mask(out_mask), .out_from_skid(out_from_skid),
    .stall_up(stall_up), .state(state));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit [3:0] slots(input int from, input int cnt, input bit [3:0] sq);
    bit [3:0] m = '0;
    for (int i = 0; i < W; i++)
      if (i >= from && i < from + cnt && !sq[i]) m[i] = 1'b1;
    return m;
  endfunction

  task automatic park(input int cnt, input bit [3:0] sq);
    if (cnt != 0 && m_occ < D) begin
      q_cnt[m_occ] = cnt;
      q_sq[m_occ]  = sq;
      m_occ++;
    end
  endtask

  task automatic drop_head();
    for (int i = 0; i < D - 1; i++) begin
      q_cnt[i] = q_cnt[i+1];
      q_sq[i]  = q_sq[i+1];
    end
    m_occ--;
  endtask

  // Reference of the requirements; returns the requirement tag for this cycle.
  task automatic model(output bit [3:0] e_mask, output bit e_skid, output int nxt, output string tag);
    int rc, ic, lim, cnt, from, left;
    bit [3:0] sq;
    bit kill, hold;
    rc   = int'(rob_free) - W;
    ic   = int'(iq_free) - W;
    lim  = (rc < ic) ? rc : ic;
    kill = squash || rob_squashing;
    hold = exec_stall || commit_stall;
    e_mask = '0;
    e_skid = 1'b0;
    nxt  = m_st;
    tag  = "R12";
    if (m_st == 4) begin
      tag = "R9";
      if (!kill) nxt = 1;
    end else if (m_st == 2) begin
      tag = "R6";
      if (kill) begin
        tag = "R9"; m_occ = 0; m_off = 0; nxt = 4;
      end else begin
        park(in_count, in_squashed);
        if (!hold && rc > 0 && ic > 0 && free_regs != 0) nxt = (m_occ == 0) ? 1 : 3;
      end
    end else begin
      if (m_st == 3) begin
        cnt = q_cnt[0]; sq = q_sq[0]; from = m_off; tag = "R7";
      end else begin
        cnt = in_count; sq = in_squashed; from = 0;
      end
      left = cnt - from;
      if (kill) begin
        tag = "R9"; m_occ = 0; m_off = 0; nxt = 4;
      end else if (hold) begin
        if (m_st != 3) tag = "R5";
        park(in_count, in_squashed); nxt = 2;
      end else if (m_st != 3 && in_count == 0) begin
        tag = "R12";
      end else if (lim <= 0) begin
        tag = "R3"; park(in_count, in_squashed); nxt = 2;
      end else if (lim < left) begin
        tag = "R4";
        e_mask = slots(from, lim, sq);
        e_skid = (m_st == 3);
        m_off = from + lim;
        park(in_count, in_squashed); nxt = 2;
      end else begin
        e_mask = slots(from, left, sq);
        e_skid = (m_st == 3);
        m_off = 0;
        if (m_st == 3) begin
          drop_head();
          park(in_count, in_squashed);
          nxt = (m_occ == 0) ? 1 : 3;
        end else begin
          nxt = 1;
          if (lim == left) tag = "R2";
          else if (sq != 0) tag = "R8";
          else tag = "R10";
        end
      end
    end
  endtask

  task automatic cyc(input int cnt, input bit [3:0] sq, input int rob, input int iq,
                     input bit es, input bit cs, input bit sqh, input bit rsq, input int fr);
    bit [3:0] e_mask;
    bit e_skid;
    int nxt;
    string tag;
    @(negedge clk);
    in_count = 3'(cnt); in_squashed = sq; rob_free = 8'(rob); iq_free = 8'(iq);
    exec_stall = es; commit_stall = cs; squash = sqh; rob_squashing = rsq; free_regs = 8'(fr);
    #2;
    check("R1", int'(state), m_st, "state");
    model(e_mask, e_skid, nxt, tag);
    check(tag, int'(out_mask), int'(e_mask), "out_mask");
    check(tag, int'(out_from_skid), int'(e_skid), "out_from_skid");
    check("R11", int'(stall_up), int'(nxt == 2 || nxt == 3), "stall_up");
    m_st = nxt;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_st = 0; m_off = 0; m_occ = 0;
    rst_n = 1'b0;
    in_count = '0; in_squashed = '0; rob_free = 8'd40; iq_free = 8'd40; free_regs = 8'd10;
    exec_stall = 1'b0; commit_stall = 1'b0; squash = 1'b0; rob_squashing = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check("R1", int'(state), 0, "reset state");
    check("R1", int'(stall_up), 0, "reset stall_up");
    check("R1", int'(out_mask), 0, "reset out_mask");
    @(negedge clk);
    rst_n = 1'b1;

    cyc(0, 4'h0, 40, 40, 0, 0, 0, 0, 10);  // R12 idle stays idle with no input
    cyc(4, 4'h0, 40, 40, 0, 0, 0, 0, 10);  // R10 full group
    cyc(3, 4'h2, 40, 40, 0, 0, 0, 0, 10);  // R8 squashed slot skipped
    cyc(4, 4'h0, 8, 30, 0, 0, 0, 0, 10);   // R2 limit exactly 4
    cyc(4, 4'h1, 6, 30, 0, 0, 0, 0, 10);   // R4 limit 2 with slot 0 squashed
    cyc(0, 4'h0, 6, 30, 0, 0, 0, 0, 0);    // R6 no free regs keeps blocked
    cyc(2, 4'h0, 30, 30, 1, 0, 0, 0, 5);   // R6 arrival appended while stalled
    cyc(0, 4'h0, 30, 30, 0, 0, 0, 0, 5);   // R6 to unblocking
    cyc(0, 4'h0, 30, 30, 0, 0, 0, 0, 5);   // R7 resume at slot 2
    cyc(0, 4'h0, 30, 30, 0, 0, 0, 0, 5);   // R7 second group, back to running
    cyc(4, 4'h0, 3, 30, 0, 0, 0, 0, 5);    // R3 credit negative
    cyc(0, 4'h0, 30, 30, 0, 0, 0, 0, 5);
    cyc(0, 4'h0, 30, 30, 0, 1, 0, 0, 5);   // R5 commit stall in unblocking
    cyc(1, 4'h0, 30, 30, 0, 0, 1, 0, 5);   // R9 squash with group parked
    cyc(0, 4'h0, 30, 30, 0, 0, 0, 1, 5);   // R9 still squashing
    cyc(0, 4'h0, 30, 30, 0, 0, 0, 0, 5);   // R9 leave to running
    cyc(4, 4'h8, 30, 30, 0, 0, 0, 0, 5);   // R10 starts at slot 0
    cyc(2, 4'h0, 30, 30, 1, 0, 0, 0, 5);   // R5 downstream stall in running

    for (int k = 0; k < 4000; k++) begin
      int cnt, rob, iq, fr;
      bit es, cs, sqh, rsq;
      bit [3:0] sq;
      cnt = $urandom_range(0, 4);
      if ((m_st == 2 || m_st == 3) && (m_occ >= D || $urandom_range(0, 9) < 6)) cnt = 0;
      sq  = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      rob = $urandom_range(2, 10);
      iq  = $urandom_range(3, 12);
      es  = ($urandom_range(0, 9) == 0);
      cs  = ($urandom_range(0, 14) == 0);
      sqh = ($urandom_range(0, 39) == 0);
      rsq = ($urandom_range(0, 29) == 0);
      fr  = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 50);
      cyc(cnt, sq, rob, iq, es, cs, sqh, rsq, fr);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule